// File: doc/BRIEF.md
# Time-Sliced Multi-Plane Cell Crossbar

This block is the switching core of an N-port cell switch. It is made of K identical crossbar planes, each notionally clocked at 1/K of the line rate. Each cell crosses the fabric whole on a single plane. In every cell time the block accepts one cell per input port and one input-to-output permutation from a central scheduler. It hands both to the next plane in a fixed rotation. That plane keeps the permutation and the admitted cells unchanged for K cell times while it carries them. After that it is reloaded.

Each output draws from the planes in the same rotation. A cell admitted in cell time t therefore leaves its matched output exactly K cell times later. Cells from one input leave in the order they entered. The scheduler works exactly as it would for a single full-rate crossbar. Scheduling and queueing sit outside this block.

One clock cycle equals one cell time.

Top module: `tsx_fabric`

## Requirements
- R1: While reset is asserted and after it is released, every output drives valid low and data zero until the first admitted cells arrive.
- R2: A cell sampled on input i at clock edge e, where output o is matched to i in the same cycle, appears on output o with identical data after edge e+K, exactly K cycles later.
- R3: The decision given in cycle t is held by plane (t mod K) for K cycles. Decisions and cells given in cycles t+1 to t+K-1 do not alter what that cell delivers, even when every cycle carries a different permutation.
- R4: An output left unmatched in a cycle's decision drives valid low and data zero in the cycle where that decision's cells come out.
- R5: An output matched to an input whose valid flag is low drives valid low and data zero in the corresponding output cycle.
- R6: Cells sent from one input to one output in consecutive cycles leave in admission order, one per cycle, with no gap, loss or reordering.
- R7: Encoding of the configuration and data buses:
  - cfg_match_i[o]=1 marks output o as matched.
  - cfg_sel_i[o*SW +: SW] holds the input index for output o, where SW = max(1, clog2(N_PORTS)).
  - The cell data for port p is at bits [p*DATA_W +: DATA_W].
  - No two matched outputs may select the same input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one cycle per cell time |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | N_PORTS | Per-input cell valid |
| in_data_i | input | N_PORTS*DATA_W | Per-input cell data |
| cfg_match_i | input | N_PORTS | Per-output matched flag of this cycle's decision |
| cfg_sel_i | input | N_PORTS*SW | Per-output selected input index |
| out_valid_o | output | N_PORTS | Per-output delivered cell valid |
| out_data_o | output | N_PORTS*DATA_W | Per-output delivered cell data |

## Verification
The bench runs all 24 permutations of a four-port, three-plane fabric back to back. A plane that is overwritten before its window ends, or an output that reads the wrong plane, shows up as the wrong data K cycles later.

Random partial matches with random input valids follow. They target the unmatched and idle-input cases, where a design that leaked stale plane contents would raise a valid flag wrongly.

A run of consecutive cells on one path checks ordering and latency. An off-by-one in the rotation or in the output pick shows up as skipped or repeated sequence numbers.

// File: rtl/tsx_pkg.sv
package tsx_pkg;
  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tsx_slot_ring.sv
module tsx_slot_ring #(
  parameter int unsigned N_PLANES = 3,
  localparam int unsigned SLW = tsx_pkg::idx_w(N_PLANES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic [SLW-1:0]      slot_o,
  output logic [N_PLANES-1:0] load_o
);
  logic [SLW-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= '0;
    else if (slot_q == SLW'(N_PLANES - 1)) slot_q <= '0;
    else slot_q <= slot_q + SLW'(1);
  end

  for (genvar p = 0; p < N_PLANES; p++) begin : g_load
    assign load_o[p] = (slot_q == SLW'(p));
  end

  assign slot_o = slot_q;

  // R3
  slot_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(slot_q) < N_PLANES);

  // R3
  slot_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(slot_q) != N_PLANES - 1) |=> (slot_q == $past(slot_q) + SLW'(1)));

  // R6
  load_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(load_o) == 1);
endmodule

// File: rtl/tsx_plane.sv
module tsx_plane #(
  parameter int unsigned N_PORTS = 4,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned SW     = tsx_pkg::idx_w(N_PORTS),
  localparam int unsigned NPAD   = 1 << SW
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic [N_PORTS-1:0]        in_valid_i,
  input  logic [N_PORTS*DATA_W-1:0] in_data_i,
  input  logic [N_PORTS-1:0]        cfg_match_i,
  input  logic [N_PORTS*SW-1:0]     cfg_sel_i,
  output logic [N_PORTS-1:0]        match_o,
  output logic [N_PORTS-1:0]        cell_valid_o,
  output logic [N_PORTS*DATA_W-1:0] cell_data_o
);
  logic [N_PORTS-1:0]        valid_q, match_q;
  logic [N_PORTS*DATA_W-1:0] data_q;
  logic [N_PORTS*SW-1:0]     sel_q;

  // plane holds decision and cells for its whole K-cycle window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      match_q <= '0;
      data_q  <= '0;
      sel_q   <= '0;
    end else if (load_i) begin
      valid_q <= in_valid_i;
      match_q <= cfg_match_i;
      data_q  <= in_data_i;
      sel_q   <= cfg_sel_i;
    end
  end

  // padded so any select value indexes safely
  logic [NPAD-1:0]   vpad;
  logic [DATA_W-1:0] dpad [NPAD];

  always_comb begin
    vpad = '0;
    vpad[N_PORTS-1:0] = valid_q;
    for (int i = 0; i < NPAD; i++) dpad[i] = '0;
    for (int i = 0; i < N_PORTS; i++) dpad[i] = data_q[i*DATA_W +: DATA_W];
  end

  for (genvar o = 0; o < N_PORTS; o++) begin : g_mux
    logic [SW-1:0] sel;
    logic          hit;
    assign sel = sel_q[o*SW +: SW];
    assign hit = match_q[o] & vpad[sel];
    assign cell_valid_o[o] = hit;
    assign cell_data_o[o*DATA_W +: DATA_W] = hit ? dpad[sel] : '0;
  end

  assign match_o = match_q;
endmodule

// File: rtl/tsx_collect.sv
module tsx_collect #(
  parameter int unsigned N_PORTS  = 4,
  parameter int unsigned N_PLANES = 3,
  parameter int unsigned DATA_W   = 8,
  localparam int unsigned SLW     = tsx_pkg::idx_w(N_PLANES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [SLW-1:0]            slot_i,
  input  logic [N_PORTS-1:0]        plane_valid_i [N_PLANES],
  input  logic [N_PORTS*DATA_W-1:0] plane_data_i  [N_PLANES],
  output logic [N_PORTS-1:0]        out_valid_o,
  output logic [N_PORTS*DATA_W-1:0] out_data_o
);
  logic [N_PORTS-1:0]        pick_valid;
  logic [N_PORTS*DATA_W-1:0] pick_data;

  // read the plane whose window closes at this edge, before it reloads
  always_comb begin
    pick_valid = '0;
    pick_data  = '0;
    for (int p = 0; p < N_PLANES; p++) begin
      if (slot_i == SLW'(p)) begin
        pick_valid = plane_valid_i[p];
        pick_data  = plane_data_i[p];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= '0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= pick_valid;
      out_data_o  <= pick_data;
    end
  end
endmodule

// File: rtl/tsx_fabric.sv
module tsx_fabric #(
  parameter int unsigned N_PORTS  = 4,
  parameter int unsigned N_PLANES = 3,
  parameter int unsigned DATA_W   = 8,
  localparam int unsigned SW      = tsx_pkg::idx_w(N_PORTS),
  localparam int unsigned SLW     = tsx_pkg::idx_w(N_PLANES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_PORTS-1:0]        in_valid_i,
  input  logic [N_PORTS*DATA_W-1:0] in_data_i,
  input  logic [N_PORTS-1:0]        cfg_match_i,
  input  logic [N_PORTS*SW-1:0]     cfg_sel_i,
  output logic [N_PORTS-1:0]        out_valid_o,
  output logic [N_PORTS*DATA_W-1:0] out_data_o
);
  logic [SLW-1:0]            slot;
  logic [N_PLANES-1:0]       load;
  logic [N_PORTS-1:0]        plane_valid [N_PLANES];
  logic [N_PORTS*DATA_W-1:0] plane_data  [N_PLANES];
  logic [N_PORTS-1:0]        plane_match [N_PLANES];

  tsx_slot_ring #(.N_PLANES(N_PLANES)) i_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slot_o (slot),
    .load_o (load)
  );

  for (genvar p = 0; p < N_PLANES; p++) begin : g_plane
    tsx_plane #(.N_PORTS(N_PORTS), .DATA_W(DATA_W)) i_plane (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .load_i       (load[p]),
      .in_valid_i   (in_valid_i),
      .in_data_i    (in_data_i),
      .cfg_match_i  (cfg_match_i),
      .cfg_sel_i    (cfg_sel_i),
      .match_o      (plane_match[p]),
      .cell_valid_o (plane_valid[p]),
      .cell_data_o  (plane_data[p])
    );
  end

  tsx_collect #(.N_PORTS(N_PORTS), .N_PLANES(N_PLANES), .DATA_W(DATA_W)) i_collect (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .slot_i        (slot),
    .plane_valid_i (plane_valid),
    .plane_data_i  (plane_data),
    .out_valid_o   (out_valid_o),
    .out_data_o    (out_data_o)
  );

  // scheduler contract: matched outputs pick distinct inputs
  logic collide;
  always_comb begin
    collide = 1'b0;
    for (int a = 0; a < N_PORTS; a++)
      for (int b = a + 1; b < N_PORTS; b++)
        if (cfg_match_i[a] && cfg_match_i[b] &&
            cfg_sel_i[a*SW +: SW] == cfg_sel_i[b*SW +: SW])
          collide = 1'b1;
  end

  // R7
  perm_distinct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !collide);

  logic [N_PORTS-1:0] match_now;
  always_comb begin
    match_now = '0;
    for (int p = 0; p < N_PLANES; p++)
      if (slot == SLW'(p)) match_now = plane_match[p];
  end

  for (genvar o = 0; o < N_PORTS; o++) begin : g_chk
    // R4
    unmatched_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !match_now[o] |=> (!out_valid_o[o] && out_data_o[o*DATA_W +: DATA_W] == '0));
  end
endmodule

// File: tb/test_tsx_fabric.sv
module test_tsx_fabric;
  localparam int N = 4;
  localparam int K = 3;
  localparam int W = 8;
  localparam int SW = 2;
  localparam int NA = 24;
  localparam int NB = 200;
  localparam int NC = 30;
  localparam int T  = NA + NB + NC + K + 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0]    in_valid_i = '0;
  logic [N*W-1:0]  in_data_i = '0;
  logic [N-1:0]    cfg_match_i = '0;
  logic [N*SW-1:0] cfg_sel_i = '0;
  logic [N-1:0]    out_valid_o;
  logic [N*W-1:0]  out_data_o;

  tsx_fabric #(.N_PORTS(N), .N_PLANES(K), .DATA_W(W)) i_tsx_fabric (.*);

  always #5 clk_i = ~clk_i;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [N-1:0]   exp_v [T];
  logic [N-1:0]   exp_m [T];
  logic [N*W-1:0] exp_d [T];
  logic [W-1:0]   prev_seq;

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic drive(input int s, input logic [N*SW-1:0] sel, input logic [N-1:0] m,
                       input logic [N-1:0] v, input logic [N*W-1:0] d);
    cfg_sel_i = sel; cfg_match_i = m; in_valid_i = v; in_data_i = d;
    exp_m[s] = m;
    for (int o = 0; o < N; o++) begin
      int i;
      i = int'(sel[o*SW +: SW]);
      exp_v[s][o] = m[o] && v[i];
      exp_d[s][o*W +: W] = (m[o] && v[i]) ? d[i*W +: W] : '0;
    end
  endtask

  task automatic check_out(input int idx);
    for (int o = 0; o < N; o++) begin
      logic ev; logic [W-1:0] ed; string tag;
      ev = (idx >= 0) ? exp_v[idx][o] : 1'b0;
      ed = (idx >= 0) ? exp_d[idx][o*W +: W] : '0;
      if (idx < 0) tag = "R1";
      else if (!exp_m[idx][o]) tag = "R4 R7";
      else if (!ev) tag = "R5";
      else tag = "R2 R3 R7";
      checks++;
      if (out_valid_o[o] !== ev || out_data_o[o*W +: W] !== ed) begin
        failures++;
        $display("FAIL %s out%0d slot%0d: valid=%b data=%h expected valid=%b data=%h",
                 tag, o, idx, out_valid_o[o], out_data_o[o*W +: W], ev, ed);
      end
    end
    if (idx > NA + NB && idx < NA + NB + NC) begin
      checks++;
      if (out_data_o[W-1:0] !== prev_seq + W'(1)) begin
        failures++;
        $display("FAIL R6 order: data=%h expected=%h", out_data_o[W-1:0], prev_seq + W'(1));
      end
    end
    prev_seq = out_data_o[W-1:0];
  endtask

  function automatic logic [N*SW-1:0] perm_of(input int code);
    int avail [N];
    int c, f, cnt;
    logic [N*SW-1:0] r;
    for (int i = 0; i < N; i++) avail[i] = i;
    cnt = N; c = code; r = '0;
    for (int o = 0; o < N; o++) begin
      int pick;
      f = 1;
      for (int j = 1; j < cnt; j++) f *= j;
      pick = c / f; c = c % f;
      r[o*SW +: SW] = SW'(avail[pick]);
      for (int j = pick; j < cnt - 1; j++) avail[j] = avail[j+1];
      cnt--;
    end
    return r;
  endfunction

  function automatic logic [N*SW-1:0] rand_perm();
    int a [N];
    logic [N*SW-1:0] r;
    for (int i = 0; i < N; i++) a[i] = i;
    for (int i = N - 1; i > 0; i--) begin
      int j, t;
      j = int'($urandom % (i + 1));
      t = a[i]; a[i] = a[j]; a[j] = t;
    end
    for (int o = 0; o < N; o++) r[o*SW +: SW] = SW'(a[o]);
    return r;
  endfunction

  initial begin
    prev_seq = '0;
    repeat (3) @(negedge clk_i);
    // R1: outputs idle while in reset
    for (int o = 0; o < N; o++) begin
      checks++;
      if (out_valid_o[o] !== 1'b0 || out_data_o[o*W +: W] !== '0) begin
        failures++;
        $display("FAIL R1 reset out%0d: valid=%b data=%h expected valid=0 data=00",
                 o, out_valid_o[o], out_data_o[o*W +: W]);
      end
    end
    rst_ni = 1'b1;
    for (int s = 0; s < T; s++) begin
      @(negedge clk_i);
      if (s >= 1) check_out(s - 1 - K);
      if (s < NA) begin
        logic [N*W-1:0] d;
        for (int i = 0; i < N; i++) d[i*W +: W] = W'(s * 16 + i * 5 + 1);
        drive(s, perm_of(s), '1, '1, d);
      end else if (s < NA + NB) begin
        logic [N*W-1:0] d;
        for (int i = 0; i < N; i++) d[i*W +: W] = W'($urandom);
        drive(s, rand_perm(), N'($urandom), N'($urandom), d);
      end else if (s < NA + NB + NC) begin
        logic [N*SW-1:0] p;
        logic [N*W-1:0] d;
        p = rand_perm();
        // force input 0 to output 0 by swapping
        for (int o = 1; o < N; o++)
          if (p[o*SW +: SW] == '0) p[o*SW +: SW] = p[SW-1:0];
        p[SW-1:0] = '0;
        for (int i = 0; i < N; i++) d[i*W +: W] = W'($urandom);
        d[W-1:0] = W'(s);
        drive(s, p, '1, '1, d);
      end else begin
        drive(s, '0, '0, '0, '0);
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule